// File: doc/BRIEF.md
# Serial Instruction-Injection Command Receiver

This block sits on the target side of a two-wire in-circuit programming link. An external host toggles a serial clock pin and drives a serial data pin. The block samples the data pin on each rising serial edge. It splits the bit stream into 4-bit control codes. It supports one command: the all-zero code, which injects an instruction. On that code the block gathers a 24-bit instruction word and presents it to the processor core for execution.

While a word is being shifted in, the core is held suspended. When the last bit of the word arrives, the block publishes the word and issues a one-cycle execute strobe. The core executes the word while the host clocks in the next control code. Any other control code raises a one-cycle unsupported flag, and the block then waits for a fresh code.

After reset the block does not decode the first command. It treats the first nine serial clocks as an injection command, whatever the data pin carries. On the first of those clocks it has the core execute a no-operation word. The first real instruction word starts on the tenth serial clock.

Both pins are asynchronous to the system clock. The block passes them through a synchronizer and detects rising serial edges in the system clock domain.

Top module: `insn_inject_rx`

## Requirements
- R1: While reset is held and directly after it, `execStb`, `cpuSuspend` and `badCode` are 0 and `insnWord` is 0, which is the no-operation word.
- R2: On the first rising serial edge after reset, `execStb` pulses and `insnWord` is 0, whatever the level of the data pin.
- R3: The first nine rising serial edges after reset form the start-up prelude. The data pin is ignored during the prelude, and `cpuSuspend` is 1 after the ninth edge.
- R4: While `cpuSuspend` is 1, 24 rising edges each sample one instruction bit. The first bit sampled becomes bit 0 of the word.
- R5: On the 24th bit, `insnWord` takes the gathered word and `execStb` pulses. In the same cycle `cpuSuspend` falls to 0.
- R6: The next four rising edges form a control code, with the first bit as bit 0. If the code is 4'b0000, `cpuSuspend` rises after the fourth edge and a new word is gathered.
- R7: Any code other than 4'b0000 pulses `badCode` for one cycle and leaves `cpuSuspend` at 0. The next four edges are decoded as a new control code.
- R8: `execStb` is never high for two cycles in a row. `insnWord` changes only in a cycle where `execStb` is high.
- R9: Asserting reset in the middle of a word abandons it. The next serial edges run the full start-up prelude again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial clock from the host, asynchronous |
| serData | input | 1 | Serial data from the host, sampled on rising serClk |
| insnWord | output | 24 | Instruction word handed to the core |
| execStb | output | 1 | One-cycle pulse: execute `insnWord` |
| cpuSuspend | output | 1 | High while an instruction word is being shifted in |
| badCode | output | 1 | One-cycle pulse on an unsupported control code |

## Verification
The bench drives the data pin high for the whole prelude. A design that decoded the prelude as a real command would flag it as unsupported and would never suspend the core. The bench uses asymmetric word patterns, so a receiver that assembled bits most significant first would publish a mirrored word.

The bench checks that the strobe arrives on the 24th bit and not the 23rd. It also checks that suspend drops in that same cycle, which catches counters that are off by one. It sends an unsupported code followed by a valid one, so a design that stalled or stayed suspended after a bad code would miss the next word. Last, it resets in the middle of a word, which exposes a design that resumed the old count instead of restarting the prelude.

// File: rtl/isr_pkg.sv
package isr_pkg;

  typedef enum logic [1:0] {
    ST_PRE  = 2'd0,
    ST_CMD  = 2'd1,
    ST_WORD = 2'd2
  } isr_state_t;

  typedef struct packed {
    logic shiftEn;
    logic loadWord;
    logic loadNop;
  } isr_strobe_t;

endpackage

// File: rtl/isr_dpath.sv
module isr_dpath
  import isr_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int CODE_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] NOP_WORD = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serClk,
  input  logic              serData,
  input  isr_strobe_t       strobe,
  output logic              bitEdge,
  output logic [CODE_W-1:0] codeBits,
  output logic [WORD_W-1:0] insnWord
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] clkSync;
  logic [SYNC_STAGES-1:0] datSync;
  logic                   clkPrev;
  logic [WORD_W-1:0]      shiftReg;
  logic [WORD_W-1:0]      shiftNext;

  // synchronizer chains, one stage per generate iteration
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        clkSync[g] <= 1'b0;
        datSync[g] <= 1'b0;
      end else if (g == 0) begin
        clkSync[g] <= serClk;
        datSync[g] <= serData;
      end else begin
        clkSync[g] <= clkSync[(g > 0) ? g - 1 : 0];
        datSync[g] <= datSync[(g > 0) ? g - 1 : 0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clkPrev <= 1'b0;
    else        clkPrev <= clkSync[LAST_STAGE];
  end

  assign bitEdge   = clkSync[LAST_STAGE] & ~clkPrev;
  // bits enter at the top, so the first bit ends at bit 0
  assign shiftNext = {datSync[LAST_STAGE], shiftReg[WORD_W-1:1]};
  assign codeBits  = shiftNext[WORD_W-1 -: CODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= shiftNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               insnWord <= NOP_WORD;
    else if (strobe.loadWord) insnWord <= shiftNext;
    else if (strobe.loadNop)  insnWord <= NOP_WORD;
  end

endmodule

// File: rtl/isr_ctrl.sv
module isr_ctrl
  import isr_pkg::*;
#(
  parameter int WORD_W  = 24,
  parameter int CODE_W  = 4,
  parameter int PRE_LEN = 9,
  parameter logic [CODE_W-1:0] SIX_CODE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bitEdge,
  input  logic [CODE_W-1:0] codeBits,
  output isr_strobe_t       strobe,
  output logic              execStb,
  output logic              cpuSuspend,
  output logic              badCode
);

  localparam int MAX_LEN = (WORD_W > PRE_LEN) ? WORD_W : PRE_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN);
  localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_LEN - 1);
  localparam logic [CNT_W-1:0] WORD_LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] CODE_LAST = CNT_W'(CODE_W - 1);

  isr_state_t       state, stateN;
  logic [CNT_W-1:0] cnt, cntN;
  logic             execN, badN;

  always_comb begin
    stateN = state;
    cntN   = cnt;
    strobe = '0;
    execN  = 1'b0;
    badN   = 1'b0;
    if (bitEdge) begin
      cntN = cnt + 1'b1;
      unique case (state)
        ST_PRE: begin
          if (cnt == '0) begin
            strobe.loadNop = 1'b1;
            execN          = 1'b1;
          end
          if (cnt == PRE_LAST) begin
            stateN = ST_WORD;
            cntN   = '0;
          end
        end
        ST_WORD: begin
          strobe.shiftEn = 1'b1;
          if (cnt == WORD_LAST) begin
            strobe.loadWord = 1'b1;
            execN           = 1'b1;
            stateN          = ST_CMD;
            cntN            = '0;
          end
        end
        ST_CMD: begin
          strobe.shiftEn = 1'b1;
          if (cnt == CODE_LAST) begin
            cntN = '0;
            if (codeBits == SIX_CODE) stateN = ST_WORD;
            else                      badN   = 1'b1;
          end
        end
        default: begin
          stateN = ST_PRE;
          cntN   = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_PRE;
      cnt        <= '0;
      execStb    <= 1'b0;
      badCode    <= 1'b0;
      cpuSuspend <= 1'b0;
    end else begin
      state      <= stateN;
      cnt        <= cntN;
      execStb    <= execN;
      badCode    <= badN;
      cpuSuspend <= (stateN == ST_WORD);
    end
  end

endmodule

// File: rtl/insn_inject_rx.sv
module insn_inject_rx
  import isr_pkg::*;
#(
  parameter int WORD_W      = 24,
  parameter int CODE_W      = 4,
  parameter int PRE_LEN     = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              serClk,
  input  logic              serData,
  output logic [WORD_W-1:0] insnWord,
  output logic              execStb,
  output logic              cpuSuspend,
  output logic              badCode
);

  isr_strobe_t       strobe;
  logic              bitEdge;
  logic [CODE_W-1:0] codeBits;

  isr_ctrl #(
    .WORD_W(WORD_W), .CODE_W(CODE_W), .PRE_LEN(PRE_LEN), .SIX_CODE('0)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bitEdge(bitEdge), .codeBits(codeBits),
    .strobe(strobe), .execStb(execStb), .cpuSuspend(cpuSuspend),
    .badCode(badCode)
  );

  isr_dpath #(
    .WORD_W(WORD_W), .CODE_W(CODE_W), .SYNC_STAGES(SYNC_STAGES),
    .NOP_WORD('0)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData),
    .strobe(strobe), .bitEdge(bitEdge), .codeBits(codeBits),
    .insnWord(insnWord)
  );

endmodule

// File: rtl/isr_checker.sv
module isr_checker #(
  parameter int WORD_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [WORD_W-1:0] insnWord,
  input logic              execStb,
  input logic              cpuSuspend,
  input logic              badCode
);

  // R5
  suspend_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpuSuspend) |-> execStb);

  // R8
  exec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    execStb |=> !execStb);

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(insnWord) |-> execStb);

  // R7
  bad_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    badCode |=> !badCode);

  // R7
  bad_no_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    badCode |-> !cpuSuspend);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!execStb && !cpuSuspend && !badCode));

endmodule

bind insn_inject_rx isr_checker #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .insnWord(insnWord), .execStb(execStb),
  .cpuSuspend(cpuSuspend), .badCode(badCode)
);

// File: tb/insn_inject_rx_bench.sv
`timescale 1ns/1ps
module insn_inject_rx_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        serClk = 1'b0;
  logic        serData = 1'b0;
  logic [23:0] insnWord;
  logic        execStb, cpuSuspend, badCode;

  int checks = 0;
  int failures = 0;
  int execCnt = 0;
  int badCnt = 0;
  logic [23:0] lastWord = '0;

  always #2.5 clk = ~clk;

  insn_inject_rx u_insn_inject_rx (
    .clk(clk), .rst_n(rst_n), .serClk(serClk), .serData(serData),
    .insnWord(insnWord), .execStb(execStb), .cpuSuspend(cpuSuspend),
    .badCode(badCode)
  );

  always @(negedge clk) begin
    if (execStb) begin
      execCnt  <= execCnt + 1;
      lastWord <= insnWord;
    end
    if (badCode) badCnt <= badCnt + 1;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic serBit(input logic b);
    @(negedge clk) serData = b;
    repeat (4) @(negedge clk);
    serClk = 1'b1;
    repeat (6) @(negedge clk);
    serClk = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendWord(input logic [23:0] w);
    for (int i = 0; i < 24; i++) serBit(w[i]);
  endtask

  task automatic sendCode(input logic [3:0] c);
    for (int i = 0; i < 4; i++) serBit(c[i]);
  endtask

  task automatic doReset();
    @(negedge clk) rst_n = 1'b0;
    serClk = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 execStb", execStb, 0);
    check("R1 cpuSuspend", cpuSuspend, 0);
    check("R1 badCode", badCode, 0);
    check("R1 insnWord", insnWord, 0);
  endtask

  task automatic testPrelude(input int baseExec);
    serBit(1'b1);
    check("R2 nop strobe", execCnt, baseExec + 1);
    check("R2 nop word", lastWord, 0);
    for (int i = 1; i < 8; i++) serBit(1'b1);
    check("R3 no suspend before ninth", cpuSuspend, 0);
    serBit(1'b1);
    check("R3 suspend after ninth", cpuSuspend, 1);
    check("R3 prelude not flagged", badCnt, 0);
  endtask

  task automatic testWord(input logic [23:0] w, input int baseExec);
    for (int i = 0; i < 23; i++) serBit(w[i]);
    check("R5 no strobe at bit 23", execCnt, baseExec);
    check("R4 suspended in word", cpuSuspend, 1);
    serBit(w[23]);
    check("R5 strobe at bit 24", execCnt, baseExec + 1);
    check("R4 word lsb first", insnWord, w);
    check("R5 suspend released", cpuSuspend, 0);
  endtask

  task automatic testSixCode();
    sendCode(4'b0000);
    check("R6 suspend after six code", cpuSuspend, 1);
  endtask

  task automatic testBadCode(input logic [3:0] c, input int baseBad);
    sendCode(c);
    check("R7 bad flagged", badCnt, baseBad + 1);
    check("R7 no suspend", cpuSuspend, 0);
  endtask

  task automatic testMidReset();
    sendWord(24'h00000F);
    doReset();
    check("R9 suspend cleared", cpuSuspend, 0);
    execCnt = 0;
    badCnt  = 0;
    testPrelude(0);
    testWord(24'h5A5A01, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog R9 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 suspend in reset", cpuSuspend, 0);
    rst_n = 1'b1;
    testReset();
    testPrelude(0);
    testWord(24'hA5C31E, 1);
    testSixCode();
    testWord(24'h123456, 2);
    testBadCode(4'b0101, 0);
    testBadCode(4'b1000, 1);
    testSixCode();
    testWord(24'hFFFFFF, 3);
    check("R8 word held", insnWord, 24'hFFFFFF);
    testSixCode();
    testWord(24'h800001, 4);
    testMidReset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule